// File: doc/BRIEF.md
# Time-Slotted Self-Diagnostic Sequencer

This block is the digital controller of a two-wire magnetic switch front end. It runs the front end in alternating slots of equal length. In the sampling slot the comparator output is latched as the switch state. In the diagnostic slot a test stimulus is driven into the sensing element, and the comparator must follow it: high first, then low. During the same slot the regulator, bias and configuration-parity monitors must all report good. A strobe resets the analog channel at the start of every slot, so that no residue carries over from one slot into the next.

Any failed diagnostic slot moves the block into a low-power safe state, which is shown on the fault flag. From there the block waits a long retry interval and then runs one diagnostic slot. It repeats this for as long as the failure remains. When a retry passes, the block resets itself internally and restarts normal slotting from its power-on condition. Slot length, retry length and stimulus settle time are parameters in clock cycles. With a 1 MHz clock, the values 70 and 2750 give 70 µs slots and a 2.75 ms retry wait.

Top module: `hall_diag_seq`

## Requirements
- R1: While reset is high and on the first cycle after it: slot_phase = 2'b00 (sampling), sw_state = 1, fault = 0, chan_rst = 1.
- R2: A sampling slot lasts SLOT_CYC cycles. sample_stb is high only on its last cycle. The value of cmp_in in that cycle appears on sw_state from the next cycle on.
- R3: chan_rst is high for exactly the first cycle of every sampling, diagnostic and retry-diagnostic slot. It stays low in the retry wait.
- R4: A diagnostic slot (slot_phase 2'b01, or 2'b11 in a retry) lasts SLOT_CYC cycles with diag_active high. inject_en is high for its first SLOT_CYC/2 cycles and low for the rest.
- R5: During a diagnostic slot sw_state does not change, whatever the field input does.
- R6: The slot fails unless cmp_in is 1 at slot cycle SETTLE_CYC and 0 at slot cycle SLOT_CYC/2+SETTLE_CYC (cycles counted from 0).
- R7: The slot fails if reg_ok, bias_ok or parity_ok is low in any cycle of a diagnostic slot, including its last cycle.
- R8: fault rises in the cycle right after the last cycle of a failed diagnostic slot, and slot_phase becomes 2'b10 (retry wait) at the same time. Monitor flags that are low during a sampling slot never raise fault.
- R9: In fault mode the retry wait lasts RETRY_CYC cycles and is followed by one retry diagnostic slot. No sample_stb occurs in fault mode.
- R10: When a retry slot passes, fault clears on the next cycle, with slot_phase = 2'b00, sw_state = 1 and chan_rst = 1.
- R11: When a retry slot fails, fault stays high and the block goes back to the retry wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Comparator (Schmitt) output |
| reg_ok | input | 1 | Regulator monitor good |
| bias_ok | input | 1 | Sensing-element bias monitor good |
| parity_ok | input | 1 | Configuration parity good |
| slot_phase | output | 2 | 00 sample, 01 diagnostic, 10 retry wait, 11 retry diagnostic |
| inject_en | output | 1 | Test stimulus drive (high half of diagnostic slot) |
| chan_rst | output | 1 | Channel reset strobe at each slot start |
| sample_stb | output | 1 | Switch-state latch strobe |
| sw_state | output | 1 | Latched switch state |
| fault | output | 1 | Safe-state / fault flag |
| diag_active | output | 1 | Diagnostic slot in progress |

## Verification
Several properties are checked on every cycle. Strobes and stimulus stay inside their own phases, channel resets appear at slot entries, and the switch state holds through diagnostic slots. Fault may only rise straight after a diagnostic slot and only fall into a fresh sampling slot, and the fault flag must agree with the phase code. Other behaviour can only be shown by the bench's scenarios: the exact slot and retry lengths, which comparator or monitor pattern counts as a failure (including a glitch on the final diagnostic cycle), that monitor flags are ignored during sampling, and that a stuck comparator keeps the block in fault until the comparator is healthy again.

// File: rtl/hds_pkg.sv
package hds_pkg;
  typedef enum logic [1:0] {
    PH_SAMPLE = 2'b00,
    PH_DIAG   = 2'b01,
    PH_WAIT   = 2'b10,
    PH_RETRY  = 2'b11
  } phase_t;
endpackage

// File: rtl/hds_slot_fsm.sv
module hds_slot_fsm
  import hds_pkg::*;
#(
  parameter int SLOT_CYC  = 70,
  parameter int RETRY_CYC = 2750,
  parameter int CW        = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_in,
  input  logic          slot_pass,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic          fault,
  output logic          sw_state
);
  localparam logic [CW-1:0] SLOT_LAST  = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_SAMPLE;
      cnt      <= '0;
      fault    <= 1'b0;
      sw_state <= 1'b1;
    end else begin
      case (phase)
        PH_SAMPLE: begin
          if (cnt == SLOT_LAST) begin
            sw_state <= cmp_in;
            phase    <= PH_DIAG;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DIAG: begin
          if (cnt == SLOT_LAST) begin
            cnt <= '0;
            if (slot_pass) begin
              phase <= PH_SAMPLE;
            end else begin
              phase <= PH_WAIT;
              fault <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt == RETRY_LAST) begin
            cnt   <= '0;
            phase <= PH_RETRY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == SLOT_LAST) begin
            cnt <= '0;
            if (slot_pass) begin
              phase    <= PH_SAMPLE;
              fault    <= 1'b0;
              sw_state <= 1'b1;
            end else begin
              phase <= PH_WAIT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hds_diag_eval.sv
module hds_diag_eval #(
  parameter int SLOT_CYC   = 70,
  parameter int SETTLE_CYC = 8,
  parameter int CW         = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          diag_on,
  input  logic [CW-1:0] cnt,
  input  logic          cmp_in,
  input  logic          reg_ok,
  input  logic          bias_ok,
  input  logic          parity_ok,
  output logic          inject_en,
  output logic          slot_pass
);
  localparam int HALF = SLOT_CYC / 2;
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] HI_AT  = CW'(SETTLE_CYC);
  localparam logic [CW-1:0] LO_AT  = CW'(HALF + SETTLE_CYC);

  logic mon_ok;
  logic hi_seen;
  logic lo_seen;
  logic mon_bad;

  assign mon_ok = reg_ok & bias_ok & parity_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_seen <= 1'b0;
      lo_seen <= 1'b0;
      mon_bad <= 1'b0;
    end else if (diag_on) begin
      if (cnt == '0) begin
        hi_seen <= 1'b0;
        lo_seen <= 1'b0;
        mon_bad <= ~mon_ok;
      end else begin
        if (cnt == HI_AT) hi_seen <= cmp_in;
        if (cnt == LO_AT) lo_seen <= ~cmp_in;
        if (!mon_ok) mon_bad <= 1'b1;
      end
    end
  end

  assign inject_en = diag_on & (cnt < HALF_C);
  assign slot_pass = hi_seen & lo_seen & ~mon_bad & mon_ok;
endmodule

// File: rtl/hds_strobe_gen.sv
module hds_strobe_gen
  import hds_pkg::*;
#(
  parameter int SLOT_CYC = 70,
  parameter int CW       = 12
) (
  input  phase_t        phase,
  input  logic [CW-1:0] cnt,
  output logic          chan_rst,
  output logic          sample_stb,
  output logic          diag_active
);
  localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_CYC - 1);

  assign chan_rst    = (phase != PH_WAIT) && (cnt == '0);
  assign sample_stb  = (phase == PH_SAMPLE) && (cnt == SLOT_LAST);
  assign diag_active = (phase == PH_DIAG) || (phase == PH_RETRY);
endmodule

// File: rtl/hall_diag_seq.sv
module hall_diag_seq
  import hds_pkg::*;
#(
  parameter int SLOT_CYC   = 70,
  parameter int RETRY_CYC  = 2750,
  parameter int SETTLE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp_in,
  input  logic       reg_ok,
  input  logic       bias_ok,
  input  logic       parity_ok,
  output logic [1:0] slot_phase,
  output logic       inject_en,
  output logic       chan_rst,
  output logic       sample_stb,
  output logic       sw_state,
  output logic       fault,
  output logic       diag_active
);
  localparam int MAXC = (SLOT_CYC > RETRY_CYC) ? SLOT_CYC : RETRY_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          slot_pass;

  hds_slot_fsm #(.SLOT_CYC(SLOT_CYC), .RETRY_CYC(RETRY_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .slot_pass(slot_pass),
    .phase(phase), .cnt(cnt), .fault(fault), .sw_state(sw_state)
  );

  hds_strobe_gen #(.SLOT_CYC(SLOT_CYC), .CW(CW)) u_stb (
    .phase(phase), .cnt(cnt), .chan_rst(chan_rst),
    .sample_stb(sample_stb), .diag_active(diag_active)
  );

  hds_diag_eval #(.SLOT_CYC(SLOT_CYC), .SETTLE_CYC(SETTLE_CYC), .CW(CW)) u_eval (
    .clk(clk), .rst(rst), .diag_on(diag_active), .cnt(cnt), .cmp_in(cmp_in),
    .reg_ok(reg_ok), .bias_ok(bias_ok), .parity_ok(parity_ok),
    .inject_en(inject_en), .slot_pass(slot_pass)
  );

  assign slot_phase = phase;
endmodule

// File: rtl/hds_checker.sv
module hds_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] slot_phase,
  input logic       inject_en,
  input logic       chan_rst,
  input logic       sample_stb,
  input logic       sw_state,
  input logic       fault,
  input logic       diag_active
);
  assert_stb_in_sample_R2: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (slot_phase == 2'b00) && !fault);

  assert_chanrst_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (slot_phase != $past(slot_phase)) && (slot_phase != 2'b10) |-> chan_rst);

  assert_no_chanrst_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (slot_phase == 2'b10) |-> !chan_rst);

  assert_inject_in_diag_R4: assert property (@(posedge clk) disable iff (rst)
    inject_en |-> diag_active);

  assert_hold_in_diag_R5: assert property (@(posedge clk) disable iff (rst)
    diag_active && $past(diag_active) |-> $stable(sw_state));

  assert_fault_after_diag_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(diag_active) && (slot_phase == 2'b10));

  assert_fault_phase_R9: assert property (@(posedge clk) disable iff (rst)
    fault == slot_phase[1]);

  assert_recover_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(fault) |-> (slot_phase == 2'b00) && sw_state && chan_rst);
endmodule

bind hall_diag_seq hds_checker u_chk (
  .clk(clk), .rst(rst), .slot_phase(slot_phase), .inject_en(inject_en),
  .chan_rst(chan_rst), .sample_stb(sample_stb), .sw_state(sw_state),
  .fault(fault), .diag_active(diag_active)
);

// File: tb/sim_hall_diag_seq.sv
`timescale 1ns/1ps
module sim_hall_diag_seq;
  localparam int SLOT   = 16;
  localparam int RETRY  = 40;
  localparam int SETTLE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic field = 1'b0;
  int   mode = 0;
  logic reg_ok = 1'b1, bias_ok = 1'b1, parity_ok = 1'b1;
  logic cmp_in;
  logic [1:0] slot_phase;
  logic inject_en, chan_rst, sample_stb, sw_state, fault, diag_active;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // Comparator model: follows the stimulus when healthy, stuck otherwise.
  assign cmp_in = diag_active ? ((mode == 0) ? inject_en : (mode == 2)) : field;

  hall_diag_seq #(.SLOT_CYC(SLOT), .RETRY_CYC(RETRY), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .reg_ok(reg_ok), .bias_ok(bias_ok),
    .parity_ok(parity_ok), .slot_phase(slot_phase), .inject_en(inject_en),
    .chan_rst(chan_rst), .sample_stb(sample_stb), .sw_state(sw_state),
    .fault(fault), .diag_active(diag_active)
  );

  // {field value, drop monitor flags during sampling}
  localparam logic [1:0] VEC [0:5] = '{2'b10, 2'b00, 2'b11, 2'b10, 2'b11, 2'b01};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_diag();
    while (!diag_active) step();
    while (diag_active) step();
  endtask

  task automatic recover();
    mode = 0;
    while (slot_phase != 2'b11) step();
    while (slot_phase == 2'b11) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    int inj;
    logic hold;
    repeat (3) step();
    // R1 reset state
    chk("R1 phase", slot_phase, 0);
    chk("R1 sw_state", sw_state, 1);
    chk("R1 fault", fault, 0);
    chk("R1 chan_rst", chan_rst, 1);
    rst = 1'b0;
    field = 1'b0;
    n = 0;
    step();
    n++;
    while (!sample_stb) begin step(); n++; end
    chk("R2 sample slot length", n, SLOT - 1);
    step();
    chk("R2 latched value", sw_state, 0);
    chk("R3 chan_rst at diag start", chan_rst, 1);
    chk("R4 phase diag", slot_phase, 1);
    n = 0; inj = 0; hold = sw_state;
    while (diag_active) begin
      n++;
      inj += int'(inject_en);
      if (sw_state != hold) chk("R5 hold during diag", sw_state, hold);
      field = ~field;
      step();
    end
    chk("R4 diag length", n, SLOT);
    chk("R4 inject length", inj, SLOT / 2);
    chk("R5 hold after diag", sw_state, 0);
    chk("R3 chan_rst at sample start", chan_rst, 1);

    // Table walk: sampling with and without monitor drops (R2, R8)
    for (int i = 0; i < 6; i++) begin
      field = VEC[i][1];
      if (VEC[i][0]) begin reg_ok = 0; bias_ok = 0; parity_ok = 0; end
      while (!sample_stb) step();
      reg_ok = 1; bias_ok = 1; parity_ok = 1;
      step();
      chk("R2 vector latch", sw_state, VEC[i][1]);
      while (diag_active) step();
      chk("R8 no fault from sample slot", fault, 0);
    end

    // Stuck-low comparator: high check fails (R6, R8)
    field = 1'b0;
    mode = 1;
    finish_diag();
    chk("R6 stuck low fault", fault, 1);
    chk("R8 phase wait", slot_phase, 2);
    n = 0;
    while (slot_phase == 2'b10) begin
      n++;
      if (sample_stb) chk("R9 no strobe in fault", 1, 0);
      step();
    end
    chk("R9 wait length", n, RETRY);
    chk("R9 retry phase", slot_phase, 3);
    chk("R3 chan_rst at retry start", chan_rst, 1);
    while (slot_phase == 2'b11) step();
    chk("R11 persistent fault", fault, 1);
    chk("R11 back to wait", slot_phase, 2);
    recover();
    chk("R10 fault cleared", fault, 0);
    chk("R10 phase sample", slot_phase, 0);
    chk("R10 sw_state power-on", sw_state, 1);
    chk("R10 chan_rst", chan_rst, 1);

    // Stuck-high comparator: low check fails (R6)
    mode = 2;
    finish_diag();
    chk("R6 stuck high fault", fault, 1);
    recover();
    chk("R10 recover again", fault, 0);

    // Regulator glitch mid-slot (R7)
    while (!diag_active) step();
    repeat (5) step();
    reg_ok = 0;
    step();
    reg_ok = 1;
    while (diag_active) step();
    chk("R7 regulator glitch", fault, 1);
    recover();

    // Parity glitch on the final diagnostic cycle (R7 boundary)
    while (!diag_active) step();
    repeat (SLOT - 1) step();
    parity_ok = 0;
    step();
    parity_ok = 1;
    chk("R7 last-cycle parity", fault, 1);
    recover();
    chk("R10 final recovery", fault, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule